// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two small integer operands and produces a product twice as wide. It uses the shift-and-add method: one add and one shift for each multiplier bit, over several clock cycles. A single strobe starts an operation. The block samples both operands and the mode select at that edge. It then runs a fixed number of steps without further input. A flag shows the operation is in flight, and a one-cycle pulse marks the cycle when the product becomes valid.

Each step takes two cycles on a single rising clock edge:

- **Add cycle.** If the lowest bit of the multiplier register is set, the double-width multiplicand register is added into the accumulator.
- **Shift cycle.** The multiplicand moves one place left, the multiplier moves one place right, and a step counter advances. The operation ends when that counter wraps back to zero.

A select input chooses unsigned or two's complement operands. In the two's complement case, the multiplicand is sign-extended when it is loaded. On the final step, if the multiplier's sign bit is set, the multiplicand is subtracted instead of added.

Top module: `seqMul`

## Requirements
- R1: While the active-low reset is held, and in the first cycle after it is released, `busy` and `done` are 0 and `product` is 0, whatever the data inputs are.
- R2: With `signedMode`=0, the final `product` equals the unsigned product of `multiplicand` and `multiplier`, for every pair of 4-bit operands.
- R3: With `signedMode`=1, both operands are read as 4-bit two's complement values (bit 3 is the sign). The final `product` is the 8-bit two's complement product. For example, 0010 times 1111 gives 11111110.
- R4: A `start` sampled high while `busy` is 0 starts an operation. `busy` is 1 from the next cycle for exactly 8 cycles (4 steps of 2 cycles), then returns to 0.
- R5: `done` is high for exactly one cycle. That cycle is the first one with `busy` back at 0, which is 9 cycles after the start edge. `product` holds the final result in that cycle.
- R6: A `start` sampled while `busy` is 1 is ignored. Neither the result nor the timing of the operation in flight changes.
- R7: Once an operation has finished, `product` holds its value until the next accepted `start`, which clears it to 0.
- R8: `multiplicand`, `multiplier` and `signedMode` are sampled only at the accepted start edge. Changing them while `busy` is 1 has no effect on the result.
- R9: Within an operation, `product` changes only on add cycles. In step k (k=0..3), it takes the partial sum of the multiplicand weighted by multiplier bit k. In signed mode, step 3 subtracts that term instead of adding it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, accepted only when idle |
| signedMode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| multiplicand | input | 4 | Multiplicand operand |
| multiplier | input | 4 | Multiplier operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 8 | Accumulated product |

## Verification
The bench builds the block with its default 4-bit operand width, which makes an exhaustive sweep practical. It covers all 256 operand pairs in each mode, and so reaches every sign combination and the subtract correction on the last step. Every cycle is compared against a behavioural model, so the partial sums on the add cycles are checked as well as the final result. Some operations also scramble the inputs and pulse a stray start while busy, to show that only the values sampled at the start edge count.

// File: rtl/seqMulPkg.sv
package seqMulPkg;
  typedef struct packed {
    logic load;
    logic addPhase;
    logic shiftPhase;
    logic lastStep;
  } mulCtl_t;
endpackage

// File: rtl/seqMulCtrl.sv
module seqMulCtrl
  import seqMulPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output mulCtl_t ctl,
  output logic    busy,
  output logic    done
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADD   = 2'd1,
    ST_SHIFT = 2'd2
  } mulState_t;

  mulState_t state;
  logic [CW-1:0] stepCnt;

  always_comb begin
    ctl.load       = (state == ST_IDLE) && start;
    ctl.addPhase   = (state == ST_ADD);
    ctl.shiftPhase = (state == ST_SHIFT);
    ctl.lastStep   = (stepCnt == LAST);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_ADD;
            stepCnt <= '0;
          end
        end
        ST_ADD: state <= ST_SHIFT;
        ST_SHIFT: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state <= ST_ADD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seqMulDatapath.sv
module seqMulDatapath
  import seqMulPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  mulCtl_t            ctl,
  input  logic               signedMode,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product
);
  localparam int PW = 2 * WIDTH;

  logic [PW-1:0]    mcandReg;
  logic [WIDTH-1:0] mplierReg;
  logic [PW-1:0]    prodReg;
  logic             signReg;
  logic [PW-1:0]    mcandExt;
  logic [PW-1:0]    sumVal;

  assign mcandExt = {{WIDTH{signedMode & multiplicand[WIDTH-1]}}, multiplicand};
  assign sumVal   = (ctl.lastStep && signReg) ? (prodReg - mcandReg)
                                              : (prodReg + mcandReg);
  assign product  = prodReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcandReg  <= '0;
      mplierReg <= '0;
      prodReg   <= '0;
      signReg   <= 1'b0;
    end else if (ctl.load) begin
      mcandReg  <= mcandExt;
      mplierReg <= multiplier;
      prodReg   <= '0;
      signReg   <= signedMode;
    end else begin
      if (ctl.addPhase && mplierReg[0]) prodReg <= sumVal;
      if (ctl.shiftPhase) begin
        mcandReg  <= {mcandReg[PW-2:0], 1'b0};
        mplierReg <= {1'b0, mplierReg[WIDTH-1:1]};
      end
    end
  end
endmodule

// File: rtl/seqMul.sv
module seqMul
  import seqMulPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               signedMode,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  mulCtl_t ctl;

  seqMulCtrl #(.WIDTH(WIDTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .ctl(ctl), .busy(busy), .done(done)
  );

  seqMulDatapath #(.WIDTH(WIDTH)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .signedMode(signedMode),
    .multiplicand(multiplicand), .multiplier(multiplier), .product(product)
  );
endmodule

// File: rtl/seqMulChecker.sv
module seqMulChecker #(
  parameter int WIDTH = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);
  localparam int RUN = 2 * WIDTH;
  logic [7:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else       busyCnt <= busy ? busyCnt + 8'd1 : 8'd0;
  end

  p_busy_after_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

  p_busy_length_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyCnt == 8'(RUN)));

  p_busy_bounded_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyCnt < 8'(RUN)));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_at_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  p_product_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(product));

  p_clear_on_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (product == '0));
endmodule

bind seqMul seqMulChecker #(.WIDTH(WIDTH)) i_checker (
  .clk(clk), .rstN(rstN), .start(start),
  .busy(busy), .done(done), .product(product)
);

// File: tb/test_seqMul.sv
`timescale 1ns/100ps
module test_seqMul;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic signedMode = 1'b0;
  logic [3:0] multiplicand = 4'd0;
  logic [3:0] multiplier = 4'd0;
  logic busy, done;
  logic [7:0] product;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit modelOn = 0;

  always #2.5 clk = ~clk;

  seqMul i_seqMul (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .multiplicand(multiplicand), .multiplier(multiplier),
    .busy(busy), .done(done), .product(product)
  );

  // behavioural reference model
  int mProd, mStep, mA, mB;
  bit mBusy, mDone, mAdd, mSgn;

  always @(posedge clk or negedge rstN) begin
    int term, aVal;
    if (!rstN) begin
      mProd = 0; mStep = 0; mBusy = 0; mDone = 0; mAdd = 0;
      mSgn = 0; mA = 0; mB = 0;
    end else begin
      mDone = 0;
      if (!mBusy) begin
        if (start) begin
          mA = int'(multiplicand); mB = int'(multiplier); mSgn = signedMode;
          mProd = 0; mStep = 0; mAdd = 1; mBusy = 1;
        end
      end else if (mAdd) begin
        aVal = (mSgn && mA >= 8) ? mA - 16 : mA;
        term = 0;
        if (((mB >> mStep) & 1) == 1) begin
          term = aVal * (1 << mStep);
          if (mSgn && mStep == 3) term = -term;
        end
        mProd = (mProd + term) & 255;
        mAdd = 0;
      end else begin
        mStep = mStep + 1;
        mAdd = 1;
        if (mStep == 4) begin
          mBusy = 0; mDone = 1;
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (modelOn && rstN && !finished) begin
      check("R4 busy", int'(busy), int'(mBusy));
      check("R5 done", int'(done), int'(mDone));
      check("R9 product", int'(product), mProd);
    end
  end

  task automatic runOp(input bit sgn, input int a, input int b,
                       input bit scramble, input bit strayStart);
    int exp, sa, sb, n;
    @(negedge clk);
    start = 1; signedMode = sgn;
    multiplicand = 4'(a); multiplier = 4'(b);
    @(negedge clk);
    start = 0;
    if (scramble) begin
      multiplicand = ~4'(a); multiplier = 4'(b + 5); signedMode = ~sgn;
    end
    n = 0;
    while (!done && n < 20) begin
      if (strayStart && n == 3) start = 1;
      else start = 0;
      @(negedge clk);
      n++;
    end
    start = 0;
    check("R5 done latency", n, 8);
    if (sgn) begin
      sa = (a >= 8) ? a - 16 : a;
      sb = (b >= 8) ? b - 16 : b;
      exp = (sa * sb) & 255;
      check("R3 signed product", int'(product), exp);
    end else begin
      exp = a * b;
      check("R2 unsigned product", int'(product), exp);
    end
    if (scramble) check("R8 inputs ignored while busy", int'(product), exp);
    if (strayStart) check("R6 start while busy ignored", int'(product), exp);
    @(negedge clk);
    @(negedge clk);
    check("R7 product hold", int'(product), exp);
  endtask

  initial begin
    multiplicand = 4'hF; multiplier = 4'hF; start = 1;
    repeat (3) @(negedge clk);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset done", int'(done), 0);
    check("R1 reset product", int'(product), 0);
    rstN = 1; start = 0;
    @(negedge clk);
    check("R1 after reset product", int'(product), 0);
    check("R1 after reset busy", int'(busy), 0);
    modelOn = 1;
    // R3 example: 0010 * 1111 = 11111110
    runOp(1'b1, 2, 15, 1'b0, 1'b0);
    check("R3 example", int'(product), 8'b11111110);
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          runOp(s[0], a, b, ((a + b) % 7 == 0), ((a * 3 + b) % 11 == 0));
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog R5 actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule